// File: doc/BRIEF.md
# 64-bit SECDED Check Generator and Decoder

This block protects a 64-bit memory word with eight check bits. Each check bit is the parity of a fixed subset of data bits, chosen by a pair of 32-bit masks: one for the upper half of the word and one for the lower half. The same parity network serves writes and reads. A write path takes `gen_check` as the check bits to store. A read path presents the stored data with its stored check bits, and the block reports what went wrong and returns corrected values.

On a read, the freshly computed check bits are XORed with the received ones to form the syndrome. The decoder first compares the syndrome against the signature column of each of the 64 data bits. A match names a faulty data bit, which is flipped back. If no data column matches, the syndrome is treated as pointing at the check field itself. A syndrome with a single bit set names one faulty check bit. Any other nonzero syndrome is reported as uncorrectable and nothing is altered.

Every result is captured in one register stage on a cycle where `in_valid` is high. The results are presented with `out_valid` on the following cycle.

Top module: `secded64_codec`

## Requirements
- R1: Check bit i of `gen_check` equals the XOR of (data[63:32] AND upper mask i) and (data[31:0] AND lower mask i). The upper/lower mask pairs for i = 0..7 are f00fe11e/c33c0ff7, 00ff00ff/00fff0ff, 0f0f0f0f/0f0fff00, 11113333/7777000f, 22224444/8888222f, 44448888/ffff4441, 8888ffff/11118882, ffff1111/22221114.
- R2: `out_syndrome` equals the check bits computed from the received data XOR the received check bits.
- R3: A zero syndrome sets `out_class` to 4'b0001 (no error). Data and check bits pass through unchanged, and both indices are 0.
- R4: The column of data bit b has, as its bit i, bit (b mod 32) of the upper mask i when b >= 32, or of the lower mask i when b < 32. A nonzero syndrome equal to a column sets `out_class` to 4'b0010 and `out_data_idx` to b, with the lowest such b winning. It also flips data bit b, and the check bits pass unchanged.
- R5: A syndrome that matches no data column and has exactly one bit set, at position k, sets `out_class` to 4'b0100 and `out_chk_idx` to k. It also flips check bit k and leaves the data unchanged.
- R6: A syndrome that matches no data column and has two or more bits set sets `out_class` to 4'b1000 (uncorrectable). Data and check bits are left unchanged and both indices are 0.
- R7: All outputs are registered. On a rising edge with `in_valid` high they take the result for the current inputs, and `out_valid` is high for exactly the next cycle. With `in_valid` low, every output except `out_valid` holds, and `out_valid` is low.
- R8: While `rst_n` is low at a rising edge, all outputs are cleared to zero, including `out_class` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs are to be captured this cycle |
| in_data | input | 64 | Data word (received, or to be encoded) |
| in_check | input | 8 | Received check bits |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| gen_check | output | 8 | Check bits computed from the captured data |
| out_syndrome | output | 8 | Syndrome of the captured word |
| out_class | output | 4 | One-hot: bit0 none, bit1 data error, bit2 check error, bit3 uncorrectable |
| out_data_idx | output | 6 | Faulty data bit index (data error only) |
| out_chk_idx | output | 3 | Faulty check bit index (check error only) |
| out_data | output | 64 | Corrected data |
| out_check | output | 8 | Corrected check bits |

## Verification
The assertions check on every cycle the relationships that hold between outputs of separate logic pieces. The class is one-hot whenever `out_valid` is high. The syndrome matches the generated check bits XOR the captured check bits. Corrected data and check bits differ from the captured ones exactly at the reported index, for the reported class. The assertions also check the one-cycle valid timing and the holding of outputs while idle. They cannot show that the parity masks are the right ones, or that the column search picks the correct bit. Only the bench's scenarios show those: clean words, every single data-bit flip, every single check-bit flip, and double flips are compared against a model computed from the mask table.

// File: rtl/secded64_pkg.sv
// Shared constants for the 64-bit SECDED codec: widths, the parity mask
// table and the class bit positions. Assumes a 64-bit word split in halves.
package secded64_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int HALF_W = DATA_W / 2;
    localparam int DIDX_W = $clog2(DATA_W);
    localparam int CIDX_W = $clog2(CHK_W);
    localparam int CLS_W  = 4;

    // Positions of the one-hot class bits
    localparam int CLS_NONE  = 0;
    localparam int CLS_DATA  = 1;
    localparam int CLS_CHECK = 2;
    localparam int CLS_UNCOR = 3;

    typedef logic [HALF_W-1:0] mask_t;

    // Masks over data[63:32], index = check bit
    localparam mask_t MASK_HI [CHK_W] = '{
        32'hf00fe11e, 32'h00ff00ff, 32'h0f0f0f0f, 32'h11113333,
        32'h22224444, 32'h44448888, 32'h8888ffff, 32'hffff1111
    };
    // Masks over data[31:0], index = check bit
    localparam mask_t MASK_LO [CHK_W] = '{
        32'hc33c0ff7, 32'h00fff0ff, 32'h0f0fff00, 32'h7777000f,
        32'h8888222f, 32'hffff4441, 32'h11118882, 32'h22221114
    };

    // Signature column of one data bit: which check bits it feeds
    function automatic logic [CHK_W-1:0] data_column(input int b);
        logic [CHK_W-1:0] col;
        for (int i = 0; i < CHK_W; i++) begin
            col[i] = (b >= HALF_W) ? MASK_HI[i][b-HALF_W] : MASK_LO[i][b];
        end
        return col;
    endfunction

endpackage

// File: rtl/secded64_chkgen.sv
// Parity network: computes the check bits of a data word from the mask
// table. Purely combinational; assumes data is stable for the cycle.
module secded64_chkgen
    import secded64_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  check
);

    // One parity tree per check bit
    for (genvar i = 0; i < CHK_W; i++) begin : g_par
        assign check[i] = ^({MASK_HI[i], MASK_LO[i]} & data);
    end

endmodule

// File: rtl/secded64_locate.sv
// Syndrome locator: compares the syndrome against every data column
// (lowest index wins), else looks at the check-bit field. Combinational.
// Assumes the syndrome is nonzero when any hit is to be reported.
module secded64_locate
    import secded64_pkg::*;
(
    input  logic [CHK_W-1:0]  syndrome,
    output logic              data_hit,
    output logic [DIDX_W-1:0] data_idx,
    output logic              chk_hit,
    output logic [CIDX_W-1:0] chk_idx,
    output logic              multi
);

    logic [DATA_W-1:0] col_hit;
    logic              nonzero;
    logic              single;

    assign nonzero = |syndrome;
    assign single  = nonzero && ((syndrome & (syndrome - CHK_W'(1))) == '0);

    // One comparator per data column, constant fixed at elaboration
    for (genvar b = 0; b < DATA_W; b++) begin : g_col
        localparam logic [CHK_W-1:0] COL = data_column(b);
        assign col_hit[b] = nonzero && (syndrome == COL);
    end

    // Priority encoder: lowest matching data column
    always_comb begin
        data_idx = '0;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            if (col_hit[b]) data_idx = DIDX_W'(b);
        end
    end

    // Lowest set syndrome bit names the check-bit position
    always_comb begin
        chk_idx = '0;
        for (int k = CHK_W - 1; k >= 0; k--) begin
            if (syndrome[k]) chk_idx = CIDX_W'(k);
        end
    end

    // Final classification flags
    always_comb begin
        data_hit = |col_hit;
        chk_hit  = !data_hit && single;
        multi    = !data_hit && nonzero && !single;
    end

endmodule

// File: rtl/secded64_correct.sv
// Correction stage: flips the reported data or check bit and forms the
// one-hot class. Combinational; assumes at most one hit flag is set.
module secded64_correct
    import secded64_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  check_in,
    input  logic              data_hit,
    input  logic [DIDX_W-1:0] data_idx,
    input  logic              chk_hit,
    input  logic [CIDX_W-1:0] chk_idx,
    input  logic              multi,
    output logic [DATA_W-1:0] data_fix,
    output logic [CHK_W-1:0]  check_fix,
    output logic [CLS_W-1:0]  cls,
    output logic [DIDX_W-1:0] data_idx_q,
    output logic [CIDX_W-1:0] chk_idx_q
);

    // Apply the single-bit fix and gate the indices by class
    always_comb begin
        data_fix   = data_in;
        check_fix  = check_in;
        data_idx_q = '0;
        chk_idx_q  = '0;
        cls        = '0;
        if (data_hit) begin
            data_fix[data_idx] = ~data_in[data_idx];
            data_idx_q         = data_idx;
            cls[CLS_DATA]      = 1'b1;
        end else if (chk_hit) begin
            check_fix[chk_idx] = ~check_in[chk_idx];
            chk_idx_q          = chk_idx;
            cls[CLS_CHECK]     = 1'b1;
        end else if (multi) begin
            cls[CLS_UNCOR]     = 1'b1;
        end else begin
            cls[CLS_NONE]      = 1'b1;
        end
    end

endmodule

// File: rtl/secded64_codec.sv
// 64-bit SECDED codec top: check generation, syndrome, location and
// correction, with one result register stage loaded on in_valid.
// Synchronous active-low reset clears all outputs.
module secded64_codec
    import secded64_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [CHK_W-1:0]    in_check,
    output logic                out_valid,
    output logic [CHK_W-1:0]    gen_check,
    output logic [CHK_W-1:0]    out_syndrome,
    output logic [CLS_W-1:0]    out_class,
    output logic [DIDX_W-1:0]   out_data_idx,
    output logic [CIDX_W-1:0]   out_chk_idx,
    output logic [DATA_W-1:0]   out_data,
    output logic [CHK_W-1:0]    out_check
);

    logic [CHK_W-1:0]  calc_chk;
    logic [CHK_W-1:0]  syn;
    logic              data_hit, chk_hit, multi;
    logic [DIDX_W-1:0] loc_didx, fix_didx;
    logic [CIDX_W-1:0] loc_cidx, fix_cidx;
    logic [DATA_W-1:0] data_fix;
    logic [CHK_W-1:0]  check_fix;
    logic [CLS_W-1:0]  cls;

    secded64_chkgen u_gen (
        .data  (in_data),
        .check (calc_chk)
    );

    assign syn = calc_chk ^ in_check;

    secded64_locate u_loc (
        .syndrome (syn),
        .data_hit (data_hit),
        .data_idx (loc_didx),
        .chk_hit  (chk_hit),
        .chk_idx  (loc_cidx),
        .multi    (multi)
    );

    secded64_correct u_fix (
        .data_in    (in_data),
        .check_in   (in_check),
        .data_hit   (data_hit),
        .data_idx   (loc_didx),
        .chk_hit    (chk_hit),
        .chk_idx    (loc_cidx),
        .multi      (multi),
        .data_fix   (data_fix),
        .check_fix  (check_fix),
        .cls        (cls),
        .data_idx_q (fix_didx),
        .chk_idx_q  (fix_cidx)
    );

    // Valid strobe: high for the cycle after a capture
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result register: loads on in_valid, otherwise holds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_check    <= '0;
            out_syndrome <= '0;
            out_class    <= '0;
            out_data_idx <= '0;
            out_chk_idx  <= '0;
            out_data     <= '0;
            out_check    <= '0;
        end else if (in_valid) begin
            gen_check    <= calc_chk;
            out_syndrome <= syn;
            out_class    <= cls;
            out_data_idx <= fix_didx;
            out_chk_idx  <= fix_cidx;
            out_data     <= data_fix;
            out_check    <= check_fix;
        end
    end

endmodule

// File: rtl/secded64_codec_chk.sv
// Assertion checker for secded64_codec, attached by bind. Relates the
// registered outputs to the inputs captured one cycle earlier.
module secded64_codec_chk
    import secded64_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [DATA_W-1:0]   in_data,
    input logic [CHK_W-1:0]    in_check,
    input logic                out_valid,
    input logic [CHK_W-1:0]    gen_check,
    input logic [CHK_W-1:0]    out_syndrome,
    input logic [CLS_W-1:0]    out_class,
    input logic [DIDX_W-1:0]   out_data_idx,
    input logic [CIDX_W-1:0]   out_chk_idx,
    input logic [DATA_W-1:0]   out_data,
    input logic [CHK_W-1:0]    out_check
);

    AST_SYN_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_syndrome == (gen_check ^ $past(in_check)))); // R2

    AST_NONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class[CLS_NONE]) |->
            (out_syndrome == '0 && out_data == $past(in_data)
             && out_check == $past(in_check))); // R3

    AST_DATA_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class[CLS_DATA]) |->
            (out_data == ($past(in_data) ^ (DATA_W'(1) << out_data_idx))
             && out_check == $past(in_check))); // R4

    AST_CHECK_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class[CLS_CHECK]) |->
            ($countones(out_syndrome) == 1
             && out_check == ($past(in_check) ^ (CHK_W'(1) << out_chk_idx))
             && out_data == $past(in_data))); // R5

    AST_UNCOR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class[CLS_UNCOR]) |->
            ($countones(out_syndrome) > 1 && out_data == $past(in_data)
             && out_check == $past(in_check))); // R6

    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_class) == 1)); // R7

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_class)
                       && $stable(out_syndrome))); // R7

endmodule

bind secded64_codec secded64_codec_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_check     (in_check),
    .out_valid    (out_valid),
    .gen_check    (gen_check),
    .out_syndrome (out_syndrome),
    .out_class    (out_class),
    .out_data_idx (out_data_idx),
    .out_chk_idx  (out_chk_idx),
    .out_data     (out_data),
    .out_check    (out_check)
);

// File: tb/secded64_codec_tb_top.sv
// Directed bench for secded64_codec: one task per scenario, each checks
// its own results against a model built from the requirement mask table.
module secded64_codec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_check = '0;
    logic        out_valid;
    logic [7:0]  gen_check, out_syndrome, out_check;
    logic [3:0]  out_class;
    logic [5:0]  out_data_idx;
    logic [2:0]  out_chk_idx;
    logic [63:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    secded64_codec dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_check(in_check), .out_valid(out_valid), .gen_check(gen_check),
        .out_syndrome(out_syndrome), .out_class(out_class),
        .out_data_idx(out_data_idx), .out_chk_idx(out_chk_idx),
        .out_data(out_data), .out_check(out_check)
    );

    // Mask table as written in R1
    logic [31:0] mhi [8] = '{32'hf00fe11e, 32'h00ff00ff, 32'h0f0f0f0f, 32'h11113333,
                             32'h22224444, 32'h44448888, 32'h8888ffff, 32'hffff1111};
    logic [31:0] mlo [8] = '{32'hc33c0ff7, 32'h00fff0ff, 32'h0f0fff00, 32'h7777000f,
                             32'h8888222f, 32'hffff4441, 32'h11118882, 32'h22221114};

    function automatic logic [7:0] ref_gen(input logic [63:0] d);
        logic [7:0] g = '0;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 32; j++)
                g[i] = g[i] ^ (mhi[i][j] & d[32+j]) ^ (mlo[i][j] & d[j]);
        return g;
    endfunction

    function automatic logic [7:0] ref_col(input int b);
        logic [7:0] c;
        for (int i = 0; i < 8; i++) c[i] = (b >= 32) ? mhi[i][b-32] : mlo[i][b];
        return c;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one word, then compare every output with the model (R1..R7)
    task automatic apply_and_check(input string req, input logic [63:0] d,
                                   input logic [7:0] c);
        logic [7:0]  g, s, ec;
        logic [3:0]  ecls;
        logic [5:0]  edi;
        logic [2:0]  eci;
        logic [63:0] ed;
        int          hit;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_check = c;
        @(negedge clk);
        in_valid = 1'b0;
        g = ref_gen(d); s = g ^ c; ed = d; ec = c; edi = '0; eci = '0;
        hit = -1;
        if (s != 0)
            for (int b = 63; b >= 0; b--) if (ref_col(b) == s) hit = b;
        if (s == 0) ecls = 4'b0001;
        else if (hit >= 0) begin
            ecls = 4'b0010; edi = 6'(hit); ed[hit] = ~d[hit];
        end else if ($countones(s) == 1) begin
            ecls = 4'b0100;
            for (int k = 7; k >= 0; k--) if (s[k]) eci = 3'(k);
            ec[eci] = ~c[eci];
        end else ecls = 4'b1000;
        chk(req, "out_valid", 64'(out_valid), 64'd1);
        chk("R1", "gen_check", 64'(gen_check), 64'(g));
        chk("R2", "syndrome", 64'(out_syndrome), 64'(s));
        chk(req, "class", 64'(out_class), 64'(ecls));
        chk(req, "data_idx", 64'(out_data_idx), 64'(edi));
        chk(req, "chk_idx", 64'(out_chk_idx), 64'(eci));
        chk(req, "data", out_data, ed);
        chk(req, "check", 64'(out_check), 64'(ec));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R8", "valid after reset", 64'(out_valid), 64'd0);
        chk("R8", "class after reset", 64'(out_class), 64'd0);
        chk("R8", "data after reset", out_data, 64'd0);
    endtask

    task automatic t_clean;
        logic [63:0] pats [5] = '{64'h0, 64'hffff_ffff_ffff_ffff,
            64'h0123_4567_89ab_cdef, 64'ha5a5_5a5a_dead_beef, 64'h8000_0000_0000_0001};
        foreach (pats[p]) begin
            apply_and_check("R3", pats[p], ref_gen(pats[p]));
            chk("R3", "clean class", 64'(out_class), 64'b0001);
        end
    endtask

    task automatic t_data_flip;
        logic [63:0] base = 64'h0f1e_2d3c_4b5a_6978;
        for (int b = 0; b < 64; b++) begin
            apply_and_check("R4", base ^ (64'd1 << b), ref_gen(base));
            chk("R4", "repaired word", out_data, base);
        end
    endtask

    task automatic t_check_flip;
        logic [63:0] base = 64'hfedc_ba98_7654_3210;
        for (int k = 0; k < 8; k++)
            apply_and_check("R5", base, ref_gen(base) ^ (8'd1 << k));
    endtask

    task automatic t_double;
        logic [63:0] base = 64'h1357_9bdf_2468_ace0;
        apply_and_check("R6", base ^ 64'h3, ref_gen(base));
        apply_and_check("R6", base ^ (64'd1 << 40) ^ (64'd1 << 7), ref_gen(base));
        apply_and_check("R6", base, ref_gen(base) ^ 8'h81);
        chk("R6", "uncorrectable class", 64'(out_class), 64'b1000);
    endtask

    task automatic t_hold;
        logic [63:0] kept;
        apply_and_check("R7", 64'h7777_0000_1111_2222, 8'h00);
        kept = out_data;
        @(negedge clk);
        in_data = 64'hdead_dead_dead_dead; in_check = 8'h5a;
        repeat (3) @(negedge clk);
        chk("R7", "valid low while idle", 64'(out_valid), 64'd0);
        chk("R7", "data held while idle", out_data, kept);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_clean();
        t_data_flip();
        t_check_flip();
        t_double();
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule